// File: doc/BRIEF.md
# Memory-Mapped Input/Output Register Overlay

This block wraps a 16-bit single-port synchronous RAM and, while an active-low feature enable is held low, places two special-function registers over the two lowest word addresses. Word 0 reports the state of two external binary inputs, which pass through a synchronizer first. Word 1 holds five on/off output controls that drive the block's output pins. Register bits share a word with RAM bits. The register field occupies the low bits, and every other bit of that word is ordinary memory. When the enable is high, both words are plain RAM.

Reads are registered. A read request issued in one cycle produces its word on the read port in the following cycle. A small response state machine records what kind of word is returning. Its states are RSP_IDLE (no read response, port reads zero), RSP_RAM (plain memory word), RSP_IN (memory word with the input field overlaid) and RSP_OUT (memory word with the output-register field overlaid). On every clock edge the machine moves to RSP_IN, RSP_OUT or RSP_RAM when a read is requested, chosen by the address and the enable. With no read request it moves to RSP_IDLE.

Top module: `sfr_overlay_ram`

## Requirements
- R1: During and after reset, `out_drv` is all zeros (every output off) and `rdata` is zero until a read is answered.
- R2: A read requested at a clock edge presents its word on `rdata` after that edge and until the next one; in any cycle that answers no read, `rdata` is zero.
- R3: With `feat_en_n` high, addresses 0 and 1 store and return all 16 bits like any other word, and writes to address 1 leave `out_drv` unchanged.
- R4: With `feat_en_n` low, a read of address 0 returns the synchronized inputs on bits 1:0 (bit 0 from `in_pins[0]`) and the RAM contents on bits 15:2.
- R5: A write to address 0 is an ordinary memory write even with the feature enabled; the input field cannot be written.
- R6: With `feat_en_n` low and `lb_n` low, a write to address 1 loads `wdata[4:0]` into `out_drv` (1 = on), visible after that clock edge.
- R7: With `feat_en_n` low, a read of address 1 returns `out_drv` on bits 4:0 and RAM on bits 15:5, and leaves `out_drv` unchanged.
- R8: Writes touch only bytes whose lane is low (`lb_n` for bits 7:0, `ub_n` for bits 15:8); a byte whose lane is high reads as zero. A write to address 1 with `lb_n` high does not change `out_drv`.
- R9: A change on `in_pins` is first returned by a read requested at the third clock edge after the change; reads requested at the first two edges still return the old value.
- R10: When a read and a write hit the same address in one cycle, the write takes effect and the read returns the contents, including the register field, from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_en_n | input | 1 | Active-low enable for the register overlay |
| addr | input | ADDR_W | Word address |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| wdata | input | 16 | Write data |
| ub_n | input | 1 | Active-low upper byte lane (bits 15:8) |
| lb_n | input | 1 | Active-low lower byte lane (bits 7:0) |
| rdata | output | 16 | Registered read data |
| in_pins | input | 2 | External binary inputs, asynchronous |
| out_drv | output | 5 | On/off output controls |

## Verification
The bench builds the block with ADDR_W set to 4, a 16-word array, and keeps the default two-stage synchronizer and the 2-bit and 5-bit register widths. The small array lets a short vector table write and read back the overlaid words next to a plain word, with the enable both high and low and with every byte-lane combination. The two-stage default makes the input latency boundary exact: the bench holds a continuous read of word 0 and watches the change arrive at the third edge. The reset, idle-zero and same-cycle read/write cases are covered by directed tests.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    // Kind of word being returned on the read port in the current cycle
    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_RAM  = 2'd1,
        RSP_IN   = 2'd2,
        RSP_OUT  = 2'd3
    } rsp_state_e;

endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/sfr_ram.sv
module sfr_ram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ub_n,
    input  logic              lb_n,
    output logic [DATA_W-1:0] rd_q
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int HALF  = DATA_W / 2;

    logic [DATA_W-1:0] mem [DEPTH];

    // Byte-lane write; the read samples the word before this edge's write
    always_ff @(posedge clk) begin
        if (wr_en && !lb_n) mem[addr][HALF-1:0]      <= wdata[HALF-1:0];
        if (wr_en && !ub_n) mem[addr][DATA_W-1:HALF] <= wdata[DATA_W-1:HALF];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= mem[addr];
    end

endmodule

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
    import sfr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int IN_W   = 2,
    parameter int OUT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              feat_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [OUT_W-1:0]  wdata_lo,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic [IN_W-1:0]   in_sync,
    input  logic [DATA_W-1:0] ram_q,
    output logic [DATA_W-1:0] rdata,
    output logic [OUT_W-1:0]  out_drv
);

    localparam int HALF = DATA_W / 2;
    localparam logic [ADDR_W-1:0] ADDR_IN  = '0;
    localparam logic [ADDR_W-1:0] ADDR_OUT = ADDR_W'(1);

    rsp_state_e        state, nxt;
    logic              sel_in, sel_out, odr_load;
    logic [IN_W-1:0]   in_snap;
    logic [OUT_W-1:0]  out_snap;
    logic              lane_lo, lane_hi;
    logic [DATA_W-1:0] word;

    assign sel_in   = !feat_en_n && (addr == ADDR_IN);
    assign sel_out  = !feat_en_n && (addr == ADDR_OUT);
    assign odr_load = wr_en && sel_out && !lb_n;

    // Next response kind
    always_comb begin
        if (!rd_en)       nxt = RSP_IDLE;
        else if (sel_in)  nxt = RSP_IN;
        else if (sel_out) nxt = RSP_OUT;
        else              nxt = RSP_RAM;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RSP_IDLE;
        else        state <= nxt;
    end

    // Snapshots taken with the read request (before any same-cycle write)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_snap  <= '0;
            out_snap <= '0;
            lane_lo  <= 1'b0;
            lane_hi  <= 1'b0;
        end else if (rd_en) begin
            in_snap  <= in_sync;
            out_snap <= out_drv;
            lane_lo  <= !lb_n;
            lane_hi  <= !ub_n;
        end
    end

    // Output drive register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        out_drv <= '0;
        else if (odr_load) out_drv <= wdata_lo;
    end

    // Output word assembly
    always_comb begin
        word = ram_q;
        unique case (state)
            RSP_IDLE: word = '0;
            RSP_RAM:  word = ram_q;
            RSP_IN:   word[IN_W-1:0]  = in_snap;
            RSP_OUT:  word[OUT_W-1:0] = out_snap;
        endcase
        if (!lane_lo) word[HALF-1:0]      = '0;
        if (!lane_hi) word[DATA_W-1:HALF] = '0;
        rdata = word;
    end

    AST_ODR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        odr_load |=> (out_drv == $past(wdata_lo))); // R6
    AST_ODR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !odr_load |=> $stable(out_drv)); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0)); // R2
    AST_PLAIN_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && feat_en_n) |=> (state == RSP_RAM)); // R3

endmodule

// File: rtl/sfr_overlay_ram.sv
module sfr_overlay_ram #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int IN_W        = 2,
    parameter int OUT_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              feat_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ub_n,
    input  logic              lb_n,
    output logic [DATA_W-1:0] rdata,
    input  logic [IN_W-1:0]   in_pins,
    output logic [OUT_W-1:0]  out_drv
);

    logic [IN_W-1:0]   in_sync;
    logic [DATA_W-1:0] ram_q;

    sfr_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (in_pins),
        .dout (in_sync)
    );

    sfr_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (addr),
        .wr_en(wr_en),
        .rd_en(rd_en),
        .wdata(wdata),
        .ub_n (ub_n),
        .lb_n (lb_n),
        .rd_q (ram_q)
    );

    sfr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IN_W(IN_W), .OUT_W(OUT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .feat_en_n(feat_en_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wdata_lo (wdata[OUT_W-1:0]),
        .ub_n     (ub_n),
        .lb_n     (lb_n),
        .in_sync  (in_sync),
        .ram_q    (ram_q),
        .rdata    (rdata),
        .out_drv  (out_drv)
    );

endmodule

// File: tb/tb_sfr_overlay_ram.sv
module tb_sfr_overlay_ram;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        feat_en_n = 1'b1;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic        ub_n = 1'b1;
    logic        lb_n = 1'b1;
    logic [15:0] rdata;
    logic [1:0]  in_pins = 2'b10;
    logic [4:0]  out_drv;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sfr_overlay_ram #(.ADDR_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .feat_en_n(feat_en_n), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .ub_n(ub_n), .lb_n(lb_n),
        .rdata(rdata), .in_pins(in_pins), .out_drv(out_drv)
    );

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic        fn;
        logic [3:0]  a;
        logic        ub;
        logic        lb;
        logic [15:0] wd;
        logic [15:0] exp_rd;
        logic [4:0]  exp_out;
    } vec_t;

    // in_pins held at 2'b10 for the whole table
    localparam vec_t VEC [16] = '{
        '{1'b0,1'b1,1'b0,4'd0,1'b0,1'b0,16'hFFFF,16'h0000,5'h00}, // R5 write word 0
        '{1'b1,1'b0,1'b0,4'd0,1'b0,1'b0,16'h0000,16'hFFFE,5'h00}, // R4 R5 inputs overlay
        '{1'b0,1'b1,1'b0,4'd1,1'b0,1'b0,16'h1235,16'h0000,5'h15}, // R6 load outputs
        '{1'b1,1'b0,1'b0,4'd1,1'b0,1'b0,16'h0000,16'h1235,5'h15}, // R7 read outputs
        '{1'b0,1'b1,1'b1,4'd1,1'b0,1'b0,16'h0000,16'h0000,5'h15}, // R3 plain write
        '{1'b1,1'b0,1'b1,4'd1,1'b0,1'b0,16'h0000,16'h0000,5'h15}, // R3 plain read
        '{1'b1,1'b0,1'b0,4'd1,1'b0,1'b0,16'h0000,16'h0015,5'h15}, // R7 overlay on RAM
        '{1'b1,1'b0,1'b1,4'd0,1'b0,1'b0,16'h0000,16'hFFFF,5'h15}, // R3 word 0 plain
        '{1'b0,1'b1,1'b0,4'd1,1'b0,1'b1,16'h5A1F,16'h0000,5'h15}, // R8 upper lane only
        '{1'b1,1'b0,1'b1,4'd1,1'b0,1'b0,16'h0000,16'h5A00,5'h15}, // R8 upper byte written
        '{1'b1,1'b0,1'b0,4'd1,1'b1,1'b0,16'h0000,16'h0015,5'h15}, // R8 upper lane masked
        '{1'b1,1'b0,1'b0,4'd1,1'b0,1'b1,16'h0000,16'h5A00,5'h15}, // R8 lower lane masked
        '{1'b0,1'b1,1'b0,4'd5,1'b0,1'b0,16'hC3A5,16'h0000,5'h15}, // R2 plain word
        '{1'b1,1'b0,1'b0,4'd5,1'b0,1'b0,16'h0000,16'hC3A5,5'h15}, // R2 read latency
        '{1'b0,1'b1,1'b1,4'd0,1'b0,1'b0,16'h0000,16'h0000,5'h15}, // R5 clear word 0
        '{1'b1,1'b0,1'b0,4'd0,1'b0,1'b0,16'h0000,16'h0002,5'h15}  // R4 inputs only
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic op(input logic rd, input logic wr, input logic fn, input logic [3:0] a,
                      input logic ub, input logic lb, input logic [15:0] wd);
        rd_en = rd; wr_en = wr; feat_en_n = fn; addr = a; ub_n = ub; lb_n = lb; wdata = wd;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rdata in reset", rdata, 16'h0);
        check("R1 out_drv in reset", {11'h0, out_drv}, 16'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 rdata after reset", rdata, 16'h0);
        check("R1 out_drv after reset", {11'h0, out_drv}, 16'h0);

        for (int i = 0; i < 16; i++) begin
            op(VEC[i].rd, VEC[i].wr, VEC[i].fn, VEC[i].a, VEC[i].ub, VEC[i].lb, VEC[i].wd);
            check($sformatf("R2-table row %0d rdata", i), rdata, VEC[i].exp_rd);
            check($sformatf("R6-table row %0d out_drv", i), {11'h0, out_drv}, {11'h0, VEC[i].exp_out});
        end

        // R2: idle cycle reads zero
        @(negedge clk);
        check("R2 idle zero", rdata, 16'h0);

        // R10: same-cycle read and write of word 1
        op(1'b1, 1'b1, 1'b0, 4'd1, 1'b0, 1'b0, 16'h0007);
        check("R10 old word returned", rdata, 16'h5A15);
        check("R10 write applied", {11'h0, out_drv}, 16'h0007);
        op(1'b1, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0, 16'h0000);
        check("R10 new word", rdata, 16'h0007);

        // R9: continuous read of word 0 (RAM bits are zero) while inputs change
        rd_en = 1'b1; feat_en_n = 1'b0; addr = 4'd0; ub_n = 1'b0; lb_n = 1'b0;
        in_pins = 2'b01;
        @(negedge clk);
        check("R9 first edge old", rdata, 16'h0002);
        @(negedge clk);
        check("R9 second edge old", rdata, 16'h0002);
        @(negedge clk);
        check("R9 third edge new", rdata, 16'h0001);
        rd_en = 1'b0;
        @(negedge clk);

        // R1: reset mid-run turns outputs off
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", {11'h0, out_drv}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule